// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back). It looks at the register fields and control bits held in the pipeline registers. From them it picks, for each of the two execute-stage operands, where the operand comes from: the register file, the result waiting in the memory-access stage, or the result waiting in the write-back stage. It also decides when fetch and decode must be frozen and when the control bits entering execute must be cleared to make a bubble.

Two kinds of stall come out of the block. A load whose destination is read by the instruction right behind it costs one frozen cycle, because forwarding cannot supply that value in time. A branch is resolved only at the end of its memory-access stage, so each branch costs three bubble cycles. In the last of those cycles the block tells the fetch logic to take the resolved PC: the target for a taken branch, or the sequential address for a branch that is not taken. Hazards at the write-back distance are not handled here. They depend on a register file that passes write data straight through to a read of the same register in the same cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: An operand select reads 2'b10 (memory-stage result) when the memory-stage producer has its write enable high, a nonzero destination, and a destination equal to that operand's source field.
- R2: An operand select reads 2'b01 (write-back-stage result) when only the write-back-stage producer matches that source under the same conditions.
- R3: When both producers match the same source, the select reads 2'b10. The younger result wins.
- R4: A select reads 2'b00 (register file) when the source is register 0, or when no producer with its write enable high matches.
- R5: When the execute stage holds a load (mem-read high) with a nonzero destination equal to either source field of the decode-stage instruction, pc_we and ifid_we are 0 and ex_bubble is 1 in that same cycle.
- R6: A branch seen in decode while no load-use stall is active proceeds, with pc_we=1 and ex_bubble=0 in that cycle. ex_bubble is then 1 for the next three cycles. pc_we and ifid_we are 0 in the first two of those cycles and 1 in the third.
- R7: pc_redirect is 1 only in the third cycle after a branch starts. This holds the same way whether the branch is later taken or not.
- R8: After reset, and whenever neither kind of stall is active, pc_we=1, ifid_we=1, ex_bubble=0 and pc_redirect=0.
- R9: A branch flag raised in decode while the branch penalty is still running does not restart or extend the penalty.
- R10: A load-use stall in the same cycle as a branch in decode delays the branch penalty until the stall clears. A load-use stall during the third penalty cycle holds the redirect back, and fetch stays frozen until both stalls have cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | 5 | Decode-stage first source register |
| id_rs2 | input | 5 | Decode-stage second source register |
| id_is_branch | input | 1 | Decode-stage instruction is a branch |
| ex_rs1 | input | 5 | Execute-stage first source register |
| ex_rs2 | input | 5 | Execute-stage second source register |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| em_rd | input | 5 | Memory-stage destination register |
| em_we | input | 1 | Memory-stage register write enable |
| mw_rd | input | 5 | Write-back-stage destination register |
| mw_we | input | 1 | Write-back-stage register write enable |
| fwd_a | output | 2 | First operand select: 00 register file, 10 memory stage, 01 write-back stage |
| fwd_b | output | 2 | Second operand select, same coding as fwd_a |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ex_bubble | output | 1 | Clear the control bits entering execute |
| pc_redirect | output | 1 | Fetch takes the resolved branch PC in this cycle |

## Verification
Two functions can land in the same cycle: the load-use stall and the branch penalty. The first case is a branch in decode that reads the register a load in execute will write. The second is a matching load in the third penalty cycle. Both cases are driven directly. In each, the bench checks cycle by cycle that fetch stays frozen and the redirect is held back until the load-use condition is dropped, and that the three-cycle penalty then runs in full.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    localparam int REGA_W = 5;

    typedef enum logic [1:0] {
        FWD_RF = 2'b00,
        FWD_MW = 2'b01,
        FWD_EM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic              we;
        logic [REGA_W-1:0] rd;
    } prod_t;

    // A producer feeds a source when it writes a nonzero register equal to it.
    function automatic logic prod_hits(prod_t p, logic [REGA_W-1:0] src);
        return p.we && (p.rd != '0) && (p.rd == src);
    endfunction

    // The younger producer (memory stage) wins over the older one.
    function automatic fwd_sel_e fwd_pick(logic [REGA_W-1:0] src, prod_t em, prod_t mw);
        if (prod_hits(em, src))      return FWD_EM;
        else if (prod_hits(mw, src)) return FWD_MW;
        else                         return FWD_RF;
    endfunction
endpackage

// File: rtl/fwd_unit.sv
module fwd_unit
    import hzd_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0][REGA_W-1:0] srcs,
    input  prod_t                        em,
    input  prod_t                        mw,
    output logic [N_SRC-1:0][1:0]        sels
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_comb sels[g] = fwd_pick(srcs[g], em, mw);
    end
endmodule

// File: rtl/load_use_det.sv
module load_use_det
    import hzd_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0][REGA_W-1:0] id_srcs,
    input  logic                         ex_load,
    input  logic [REGA_W-1:0]            ex_rd,
    output logic                         stall
);
    logic [N_SRC-1:0] hit;
    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        always_comb hit[g] = ex_load && (ex_rd != '0) && (ex_rd == id_srcs[g]);
    end
    always_comb stall = |hit;
endmodule

// File: rtl/branch_seq.sv
module branch_seq #(
    parameter int PENALTY = 3,
    localparam int CW = $clog2(PENALTY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic id_is_branch,
    input  logic lu_stall,
    output logic busy,
    output logic freeze,
    output logic redirect
);
    logic [CW-1:0] cnt;
    logic          last;
    logic          start;

    always_comb begin
        busy     = (cnt != '0);
        last     = (cnt == CW'(1));
        start    = id_is_branch && !busy && !lu_stall;
        freeze   = busy && !last;
        redirect = last && !lu_stall;
    end

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (start)     cnt <= CW'(PENALTY);
        else if (freeze)    cnt <= cnt - CW'(1);
        else if (redirect)  cnt <= '0;
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int BR_PENALTY = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] id_rs1,
    input  logic [4:0] id_rs2,
    input  logic       id_is_branch,
    input  logic [4:0] ex_rs1,
    input  logic [4:0] ex_rs2,
    input  logic [4:0] ex_rd,
    input  logic       ex_mem_read,
    input  logic [4:0] em_rd,
    input  logic       em_we,
    input  logic [4:0] mw_rd,
    input  logic       mw_we,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b,
    output logic       pc_we,
    output logic       ifid_we,
    output logic       ex_bubble,
    output logic       pc_redirect
);
    logic [1:0][REGA_W-1:0] ex_srcs, id_srcs;
    logic [1:0][1:0]        sels;
    prod_t                  em_p, mw_p;
    logic                   lu_stall, br_busy, br_freeze, br_redirect;

    always_comb begin
        ex_srcs = {ex_rs2, ex_rs1};
        id_srcs = {id_rs2, id_rs1};
        em_p    = '{we: em_we, rd: em_rd};
        mw_p    = '{we: mw_we, rd: mw_rd};
    end

    fwd_unit #(.N_SRC(2)) u_fwd (
        .srcs(ex_srcs), .em(em_p), .mw(mw_p), .sels(sels)
    );

    load_use_det #(.N_SRC(2)) u_lu (
        .id_srcs(id_srcs), .ex_load(ex_mem_read), .ex_rd(ex_rd), .stall(lu_stall)
    );

    branch_seq #(.PENALTY(BR_PENALTY)) u_br (
        .clk(clk), .rst(rst), .id_is_branch(id_is_branch), .lu_stall(lu_stall),
        .busy(br_busy), .freeze(br_freeze), .redirect(br_redirect)
    );

    always_comb begin
        fwd_a       = sels[0];
        fwd_b       = sels[1];
        pc_we       = !lu_stall && !br_freeze;
        ifid_we     = !lu_stall && !br_freeze;
        ex_bubble   = lu_stall || br_busy;
        pc_redirect = br_redirect;
    end
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] id_rs1,
    input logic [4:0] id_rs2,
    input logic       id_is_branch,
    input logic [4:0] ex_rs1,
    input logic [4:0] ex_rd,
    input logic       ex_mem_read,
    input logic [4:0] em_rd,
    input logic       em_we,
    input logic [4:0] mw_rd,
    input logic       mw_we,
    input logic [1:0] fwd_a,
    input logic       pc_we,
    input logic       ifid_we,
    input logic       ex_bubble,
    input logic       pc_redirect
);
    logic em_hit, mw_hit, lu_hit;
    always_comb begin
        em_hit = em_we && (em_rd != 5'd0) && (em_rd == ex_rs1);
        mw_hit = mw_we && (mw_rd != 5'd0) && (mw_rd == ex_rs1);
        lu_hit = ex_mem_read && (ex_rd != 5'd0) && (ex_rd == id_rs1 || ex_rd == id_rs2);
    end

    assert_fwd_em_R1: assert property (@(posedge clk) disable iff (rst)
        em_hit |-> fwd_a == 2'b10);
    assert_fwd_mw_R2: assert property (@(posedge clk) disable iff (rst)
        (mw_hit && !em_hit) |-> fwd_a == 2'b01);
    assert_fwd_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (ex_rs1 == 5'd0) |-> fwd_a == 2'b00);
    assert_lu_hold_R5: assert property (@(posedge clk) disable iff (rst)
        lu_hit |-> (!pc_we && !ifid_we && ex_bubble));
    assert_br_shadow_R6: assert property (@(posedge clk) disable iff (rst)
        (id_is_branch && !ex_bubble) |=> (ex_bubble && !pc_we && !pc_redirect));
    assert_redirect_R7: assert property (@(posedge clk) disable iff (rst)
        pc_redirect |-> (ex_bubble && pc_we && ifid_we));
    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !ex_bubble |-> (pc_we && ifid_we && !pc_redirect));
endmodule

bind hazard_ctrl hazard_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_branch(id_is_branch),
    .ex_rs1(ex_rs1), .ex_rd(ex_rd), .ex_mem_read(ex_mem_read), .em_rd(em_rd),
    .em_we(em_we), .mw_rd(mw_rd), .mw_we(mw_we), .fwd_a(fwd_a), .pc_we(pc_we),
    .ifid_we(ifid_we), .ex_bubble(ex_bubble), .pc_redirect(pc_redirect)
);

// File: tb/test_hazard_ctrl.sv
`timescale 1ns/1ps
module test_hazard_ctrl;
    logic clk = 0, rst = 1;
    logic [4:0] id_rs1 = 0, id_rs2 = 0, ex_rs1 = 0, ex_rs2 = 0, ex_rd = 0, em_rd = 0, mw_rd = 0;
    logic id_is_branch = 0, ex_mem_read = 0, em_we = 0, mw_we = 0;
    logic [1:0] fwd_a, fwd_b;
    logic pc_we, ifid_we, ex_bubble, pc_redirect;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    hazard_ctrl i_hazard_ctrl (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // status word = {pc_we, ifid_we, ex_bubble, pc_redirect}
    function automatic logic [7:0] st();
        return {4'b0, pc_we, ifid_we, ex_bubble, pc_redirect};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; id_is_branch = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        ex_mem_read = 0; em_rd = 0; em_we = 0; mw_rd = 0; mw_we = 0;
    endtask

    task automatic t_reset();
        step(); #1;
        chk("R8 reset status", st(), 8'b1100);
        chk("R4 reset fwd", {4'b0, fwd_a, fwd_b}, 8'h00);
    endtask

    task automatic t_back_to_back();
        step(); idle();
        em_we = 1; em_rd = 5'd2; ex_rs1 = 5'd2; ex_rs2 = 5'd3; #1;
        chk("R1 fwd_a from memory stage", {6'b0, fwd_a}, 8'h02);
        chk("R4 fwd_b unmatched", {6'b0, fwd_b}, 8'h00);
        chk("R8 no stall on forwarding", st(), 8'b1100);
    endtask

    task automatic t_distance_two();
        step(); idle();
        mw_we = 1; mw_rd = 5'd7; ex_rs2 = 5'd7; ex_rs1 = 5'd7; em_we = 1; em_rd = 5'd8; #1;
        chk("R2 fwd_b from write-back", {6'b0, fwd_b}, 8'h01);
        chk("R2 fwd_a from write-back", {6'b0, fwd_a}, 8'h01);
    endtask

    task automatic t_priority();
        step(); idle();
        em_we = 1; em_rd = 5'd4; mw_we = 1; mw_rd = 5'd4; ex_rs1 = 5'd4; #1;
        chk("R3 younger wins", {6'b0, fwd_a}, 8'h02);
    endtask

    task automatic t_zero_and_we();
        step(); idle();
        em_we = 1; em_rd = 5'd0; mw_we = 1; mw_rd = 5'd0; ex_rs1 = 5'd0; #1;
        chk("R4 register 0", {6'b0, fwd_a}, 8'h00);
        step(); idle();
        em_we = 0; em_rd = 5'd9; mw_we = 0; mw_rd = 5'd9; ex_rs2 = 5'd9; #1;
        chk("R4 write enable low", {6'b0, fwd_b}, 8'h00);
    endtask

    task automatic t_load_use();
        step(); idle();
        ex_mem_read = 1; ex_rd = 5'd6; id_rs2 = 5'd6; #1;
        chk("R5 load-use stall", st(), 8'b0010);
        step(); ex_mem_read = 0; #1;
        chk("R5 stall lasts one cycle", st(), 8'b1100);
        step(); ex_mem_read = 1; ex_rd = 5'd0; id_rs1 = 5'd0; #1;
        chk("R5 load to register 0 no stall", st(), 8'b1100);
    endtask

    task automatic branch_run(string tag);
        step(); idle(); id_is_branch = 1; #1;
        chk({"R6 branch proceeds ", tag}, st(), 8'b1100);
        step(); #1;   // branch flag left high: stale decode content (R9)
        chk({"R6 penalty cycle 1 ", tag}, st(), 8'b0010);
        step(); #1;
        chk({"R9 penalty cycle 2 ", tag}, st(), 8'b0010);
        step(); id_is_branch = 0; #1;
        chk({"R7 penalty cycle 3 redirect ", tag}, st(), 8'b1111);
        step(); #1;
        chk({"R8 released ", tag}, st(), 8'b1100);
    endtask

    task automatic t_branch_taken();     branch_run("taken");     endtask
    task automatic t_branch_not_taken(); branch_run("not taken"); endtask

    task automatic t_overlap_start();
        step(); idle();
        id_is_branch = 1; id_rs1 = 5'd5; ex_mem_read = 1; ex_rd = 5'd5; #1;
        chk("R10 load-use before branch", st(), 8'b0010);
        step(); ex_mem_read = 0; ex_rd = 0; #1;
        chk("R10 branch starts after stall", st(), 8'b1100);
        step(); id_is_branch = 0; #1;
        chk("R10 penalty 1", st(), 8'b0010);
        step(); #1;
        chk("R10 penalty 2", st(), 8'b0010);
        step(); #1;
        chk("R10 penalty 3", st(), 8'b1111);
    endtask

    task automatic t_overlap_last();
        step(); idle(); id_is_branch = 1; #1;
        step(); id_is_branch = 0; #1;
        step(); #1;
        step(); ex_mem_read = 1; ex_rd = 5'd3; id_rs1 = 5'd3; #1;
        chk("R10 redirect held", st(), 8'b0010);
        step(); #1;
        chk("R10 still held", st(), 8'b0010);
        step(); ex_mem_read = 0; #1;
        chk("R10 redirect after clear", st(), 8'b1111);
        step(); #1;
        chk("R8 released after overlap", st(), 8'b1100);
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_back_to_back();
        t_distance_two();
        t_priority();
        t_zero_and_we();
        t_load_use();
        t_branch_taken();
        t_branch_not_taken();
        t_overlap_start();
        t_overlap_last();
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule